// File: doc/BRIEF.md
# Configurable Interrupt Input Mapper

This block conditions four external interrupt pins and folds them into a shared 32-bit pending register. Every pin has its own 8-bit configuration field that sets four things: whether the pin is enabled, whether it is detected as a level or as a pulse, which electrical level counts as asserted, and which pending bit a detected event sets. Software reaches the configuration word, the pending register and a routing control bit through a small word-wide register port.

Each pin first passes through a two-flop synchronizer. Its polarity is then corrected. A level-mode pin sets its pending bit on every clock where it is asserted. A pulse-mode pin sets its pending bit only on the clock where the corrected level rises. Pending bits stay set until software writes a 1 to them. One interrupt output reports that some pending bit is set, but only while local routing is on.

Top module: `irq_mapper`

## Requirements
- R1: Address 0 holds the configuration word, which reads back what was written. Input n owns bits [8n+7:8n]. Within a field, bit 7 is enable, bit 6 is type, bit 5 is polarity and bits 4:0 are the vector.
- R2: An input whose enable bit is 0 never changes the pending register, whatever its pin does.
- R3: Type 0 is level mode. While the synchronized, polarity-corrected input is asserted, its pending bit is set on every clock. A pin change driven before rising edge k first shows in the pending register after edge k+2.
- R4: Type 1 is pulse mode. Only a rising edge of the corrected level sets the pending bit. A bit cleared while the pin stays asserted remains clear until the pin deasserts and asserts again.
- R5: Polarity 1 makes a pin active low. Polarity 0 makes it active high.
- R6: The 5-bit vector selects which pending bit is set. Every value from 0 to 31 is valid.
- R7: When several enabled inputs map to the same vector, they set that one pending bit as a logical OR, with no error.
- R8: Address 1 reads the pending register. Writing it clears each bit that is written as 1, and bits written as 0 are left unchanged.
- R9: When a set and a clear hit the same pending bit on the same clock, the set wins.
- R10: Address 2 bit 0 is the local-routing bit. When it is 1, `irqOut` is the OR of all pending bits. When it is 0, `irqOut` is low and the pending bits are kept.
- R11: Reset clears the configuration word, the pending register and the routing bit, so `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPins | input | 4 | Asynchronous interrupt pins |
| regAddr | input | 2 | Register select: 0 config, 1 pending, 2 control |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four inputs, a 5-bit vector and two synchronizer stages. This makes all four configuration fields reachable, along with both ends of the vector range (bits 0 and 31) and the exact three-edge latency from pin to pending bit. A cycle-accurate behavioural model checks the pending register and `irqOut` on every clock. The stimulus steps through level and pulse modes, both polarities, shared vectors, disabled inputs and a clear that arrives on the same clock as a set.

// File: rtl/irq_mapper_pkg.sv
package irq_mapper_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd2;

  typedef enum logic [1:0] {RD_CFG, RD_PEND, RD_CTL, RD_NONE} rd_sel_e;

  typedef struct packed {
    logic    cfgWe;
    logic    pendClr;
    logic    ctlWe;
    rd_sel_e rdSel;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_mapper_ctrl.sv
module irq_mapper_ctrl
  import irq_mapper_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrl_strobe_t      strobes
);
  always_comb begin
    strobes.cfgWe   = regWrEn && (regAddr == ADDR_CFG);
    strobes.pendClr = regWrEn && (regAddr == ADDR_PEND);
    strobes.ctlWe   = regWrEn && (regAddr == ADDR_CTL);
    unique case (regAddr)
      ADDR_CFG:  strobes.rdSel = RD_CFG;
      ADDR_PEND: strobes.rdSel = RD_PEND;
      ADDR_CTL:  strobes.rdSel = RD_CTL;
      default:   strobes.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/irq_mapper_datapath.sv
module irq_mapper_datapath
  import irq_mapper_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int VEC_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  localparam int FIELD_W    = VEC_W + 3,
  localparam int CFG_W      = NUM_IN * FIELD_W,
  localparam int PEND_W     = 1 << VEC_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  pins,
  input  ctrl_strobe_t       strobes,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [CFG_W-1:0]   cfgQ,
  output logic [PEND_W-1:0]  pendQ,
  output logic               routeQ,
  output logic               irqOut
);
  logic [NUM_IN-1:0] hit;
  logic [VEC_W-1:0]  vecSel [NUM_IN];
  logic [PEND_W-1:0] setMask;
  logic [PEND_W-1:0] clrMask;

  // Per-input conditioning: synchronize, correct polarity, detect
  for (genvar g = 0; g < NUM_IN; g++) begin : gIn
    logic [SYNC_STAGES-1:0] syncQ;
    logic [FIELD_W-1:0]     field;
    logic                   asserted;
    logic                   prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], pins[g]};
        prevQ <= asserted;
      end
    end

    assign field     = cfgQ[g*FIELD_W +: FIELD_W];
    assign asserted  = syncQ[SYNC_STAGES-1] ^ field[FIELD_W-3];
    assign vecSel[g] = field[VEC_W-1:0];
    assign hit[g]    = field[FIELD_W-1] &
                       (field[FIELD_W-2] ? (asserted & ~prevQ) : asserted);
  end

  always_comb begin
    setMask = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (hit[i]) setMask = setMask | (PEND_W'(1) << vecSel[i]);
  end

  assign clrMask = strobes.pendClr ? PEND_W'(wrData) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      pendQ  <= '0;
      routeQ <= 1'b0;
    end else begin
      if (strobes.cfgWe) cfgQ <= CFG_W'(wrData);
      if (strobes.ctlWe) routeQ <= wrData[0];
      pendQ <= (pendQ & ~clrMask) | setMask;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_CFG:  rdData = DATA_W'(cfgQ);
      RD_PEND: rdData = DATA_W'(pendQ);
      RD_CTL:  rdData = DATA_W'(routeQ);
      default: rdData = '0;
    endcase
  end

  assign irqOut = routeQ & (|pendQ);
endmodule

// File: rtl/irq_mapper.sv
module irq_mapper
  import irq_mapper_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int VEC_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqPins,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  localparam int FIELD_W = VEC_W + 3;
  localparam int CFG_W   = NUM_IN * FIELD_W;
  localparam int PEND_W  = 1 << VEC_W;

  ctrl_strobe_t      strobes;
  logic [CFG_W-1:0]  cfgQ;
  logic [PEND_W-1:0] pendQ;
  logic              routeQ;

  irq_mapper_ctrl uCtrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  irq_mapper_datapath #(
    .NUM_IN(NUM_IN), .VEC_W(VEC_W), .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .pins    (irqPins),
    .strobes (strobes),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .cfgQ    (cfgQ),
    .pendQ   (pendQ),
    .routeQ  (routeQ),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/irq_mapper_chk.sv
module irq_mapper_chk
  import irq_mapper_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int FIELD_W = 8,
  parameter int PEND_W  = 32,
  parameter int DATA_W  = 32
)(
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         regAddr,
  input logic                      regWrEn,
  input logic [DATA_W-1:0]         regWrData,
  input logic                      irqOut,
  input logic [NUM_IN*FIELD_W-1:0] cfgQ,
  input logic [PEND_W-1:0]         pendQ,
  input logic                      routeQ
);
  logic anyEn;
  always_comb begin
    anyEn = 1'b0;
    for (int i = 0; i < NUM_IN; i++) anyEn = anyEn | cfgQ[i*FIELD_W + FIELD_W - 1];
  end

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CFG) |=> (cfgQ == $past(regWrData[NUM_IN*FIELD_W-1:0]))); // R1

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    !anyEn |=> ((pendQ & ~$past(pendQ)) == '0)); // R2

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_PEND) |=> ((~pendQ & $past(pendQ)) == '0)); // R8

  AST_IRQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> routeQ); // R10

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pendQ != '0)); // R10
endmodule

bind irq_mapper irq_mapper_chk #(
  .NUM_IN(NUM_IN), .FIELD_W(FIELD_W), .PEND_W(PEND_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .irqOut(irqOut), .cfgQ(cfgQ), .pendQ(pendQ),
  .routeQ(routeQ)
);

// File: tb/irq_mapper_test.sv
module irq_mapper_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  irqPins = 4'h0;
  logic [1:0]  regAddr = 2'd1;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R11";

  always #10 clk = ~clk;

  irq_mapper uut (
    .clk(clk), .rstN(rstN), .irqPins(irqPins), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  // Behavioural reference model
  logic [31:0] mCfg, mPend;
  logic        mRoute;
  logic [3:0]  mPrev;
  logic [3:0]  delayQ[$];

  always @(posedge clk) begin
    logic [3:0]  seen;
    logic [3:0]  nextPrev;
    logic [31:0] setBits, clrBits;
    logic [7:0]  fld;
    logic        act;
    if (!rstN) begin
      mCfg = 0; mPend = 0; mRoute = 0; mPrev = 0;
      delayQ = '{4'h0, 4'h0};
    end else begin
      seen = delayQ.pop_front();
      delayQ.push_back(irqPins);
      setBits = 0;
      for (int i = 0; i < 4; i++) begin
        fld = mCfg[8*i +: 8];
        act = seen[i] ^ fld[5];
        nextPrev[i] = act;
        if (fld[7] && (fld[6] ? (act && !mPrev[i]) : act))
          setBits[fld[4:0]] = 1'b1;
      end
      clrBits = (regWrEn && regAddr == 2'd1) ? regWrData : 32'h0;
      mPend = (mPend & ~clrBits) | setBits;
      mPrev = nextPrev;
      if (regWrEn && regAddr == 2'd0) mCfg = regWrData;
      if (regWrEn && regAddr == 2'd2) mRoute = regWrData[0];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rstN && !done) begin
      chk({curReq, " irqOut"}, {31'b0, irqOut}, {31'b0, mRoute && (mPend != 0)});
      if (regAddr == 2'd1) chk({curReq, " pending"}, regRdData, mPend);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd1;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdData; regAddr = 2'd1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R11: reset state
    rd(2'd0, v); chk("R11 cfg", v, 0);
    rd(2'd1, v); chk("R11 pend", v, 0);
    rd(2'd2, v); chk("R11 ctl", v, 0);
    chk("R11 irq", {31'b0, irqOut}, 0);

    // R2: all disabled, pins active
    curReq = "R2";
    irqPins = 4'hF; tick(5);
    rd(2'd1, v); chk("R2 disabled pins", v, 0);
    irqPins = 4'h0; tick(3);

    // R1: field layout readback; input0 level, active high, vector 3
    curReq = "R1";
    wr(2'd0, 32'h0000_0083);
    rd(2'd0, v); chk("R1 cfg readback", v, 32'h0000_0083);

    // R3: level latency of three edges
    curReq = "R3";
    irqPins[0] = 1'b1;
    tick(1); rd(2'd1, v); chk("R3 edge1", v, 0);
    tick(1); rd(2'd1, v); chk("R3 edge2", v, 0);
    tick(1); rd(2'd1, v); chk("R3 edge3", v, 32'h8);

    // R9: clear while level still asserted, set wins
    curReq = "R9";
    wr(2'd1, 32'h8);
    rd(2'd1, v); chk("R9 set beats clear", v, 32'h8);

    // R8: write-one-to-clear, zeros ignored
    curReq = "R8";
    irqPins[0] = 1'b0; tick(3);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R8 zero write", v, 32'h8);
    wr(2'd1, 32'h8);
    rd(2'd1, v); chk("R8 clear", v, 0);

    // R10: routing off keeps pending, routing on raises irqOut
    curReq = "R10";
    irqPins[0] = 1'b1; tick(4);
    chk("R10 masked irq", {31'b0, irqOut}, 0);
    rd(2'd1, v); chk("R10 pending kept", v, 32'h8);
    wr(2'd2, 32'h1);
    chk("R10 routed irq", {31'b0, irqOut}, 1);
    irqPins[0] = 1'b0; tick(3);
    wr(2'd1, 32'h8);
    chk("R10 irq drops", {31'b0, irqOut}, 0);

    // R4 / R6: input1 pulse, active high, vector 31
    curReq = "R4";
    wr(2'd0, 32'h0000_DF83);
    irqPins[1] = 1'b1; tick(4);
    rd(2'd1, v); chk("R6 vector 31", v, 32'h8000_0000);
    wr(2'd1, 32'h8000_0000); tick(4);
    rd(2'd1, v); chk("R4 held pulse no reset", v, 0);
    irqPins[1] = 1'b0; tick(3);
    irqPins[1] = 1'b1; tick(4);
    rd(2'd1, v); chk("R4 new edge", v, 32'h8000_0000);
    wr(2'd1, 32'h8000_0000);
    irqPins[1] = 1'b0; tick(3);

    // R5 / R6: input2 level, active low, vector 0
    curReq = "R5";
    irqPins[2] = 1'b1; tick(3);
    wr(2'd0, 32'h00A0_DF83); tick(4);
    rd(2'd1, v); chk("R5 high is idle", v, 0);
    irqPins[2] = 1'b0; tick(4);
    rd(2'd1, v); chk("R6 vector 0 via active low", v, 32'h1);
    irqPins[2] = 1'b1; tick(3);
    wr(2'd1, 32'h1);
    rd(2'd1, v); chk("R5 cleared", v, 0);

    // R7: inputs 0 and 3 share vector 5
    curReq = "R7";
    wr(2'd0, 32'h85A0_DF85);
    irqPins[0] = 1'b1; irqPins[3] = 1'b1; tick(4);
    rd(2'd1, v); chk("R7 shared vector", v, 32'h20);
    irqPins[0] = 1'b0; tick(3);
    wr(2'd1, 32'h20);
    rd(2'd1, v); chk("R7 other input alone", v, 32'h20);
    irqPins[3] = 1'b0; tick(3);
    wr(2'd1, 32'h20);

    // R2: field with enable off but vector set
    curReq = "R2";
    wr(2'd0, 32'h07A0_DF85);
    irqPins[3] = 1'b1; tick(5);
    rd(2'd1, v); chk("R2 disabled field", v, 0);
    irqPins[3] = 1'b0; tick(3);

    finishRun();
  end
endmodule